// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a SPI master that works through a queue of up to 32 transfers held in on-chip storage, with no processor involvement once the queue has started. Each queue slot has three parts: a 16-bit word to send, a 16-bit word that receives the reply, and a command byte. The command byte sets the chip-select pattern for that slot and says whether chip select stays asserted into the next slot.

To use it, the host fills the slots, programs the last slot index, the serial-clock divider, the word length, the clock mode and the delays, and then sets the run bit. The sequencer works through the slots from index 0 up to and including the last one, in order. It writes every received word into the slot it came from. When the last slot is done it clears the run bit and raises a sticky finished flag.

The host side is a simple port with separate read and write addresses. Reads are combinational. The address splits into four regions: control and status registers, transmit slots, receive slots and command slots.

Top module: `qspi_master`

## Requirements
- R1: After reset the registers read as follows: setup = 0xA004, run = 0x0000, queue = 0x000F, status = 0x0000. The chip-select outputs read 4'hF and SCLK reads 0.
- R2: Address bits [6:5] select the region: 0 = registers, 1 = transmit slots, 2 = receive slots, 3 = command slots. Bits [4:0] index a slot, and bits [1:0] select a register (0 setup, 1 run, 2 queue, 3 status). While the queue is idle, host writes to the slots read back unchanged; command slots read back in bits [7:0].
- R3: A run shifts slots 0 to LAST in order, where LAST is queue[12:8]. Each transmit word goes out on MOSI MSB first, using only its low N bits.
- R4: Receive slot i captures the N bits shifted in on MISO while slot i is sent, right-aligned with zeros above them.
- R5: While slot i is active, the chip-select outputs carry bits [3:0] of command slot i. If bit 7 of that command is 1, the pattern is held straight into slot i+1. If bit 7 is 0, the outputs return to the idle level before slot i+1.
- R6: While no queue is running, the chip-select outputs equal queue[3:0], the programmable idle level.
- R7: Writing run bit 15 = 1 while idle starts the queue. Bit 15 reads 1 until the last slot ends and then clears by itself. At that point status bit 7 (finished) is set and status[4:0] reports the index of the last slot executed.
- R8: Writing 1 to status bit 7 clears the finished flag. If the sequencer sets the flag in the same cycle as such a write, the set wins.
- R9: The word length N comes from setup[13:10]. A value of 8 to 15 gives that many bits; any value below 8 gives 16 bits.
- R10: Each SCLK phase lasts B system cycles, where B is setup[7:0]. A value of 0 is treated as 2.
- R11: SCLK rests at setup[9] (polarity). With setup[8] = 0, data is sampled on the leading edge; with setup[8] = 1, on the trailing edge. SCLK is back at its resting level when each word ends.
- R12: run[14:8] adds exactly that many system cycles between chip-select assertion and the first SCLK edge of a slot. run[7:0] adds exactly that many cycles between the last SCLK edge and the end of the slot.
- R13: Writes to the setup, run and queue registers are ignored while the queue is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_waddr | input | 7 | Host write address |
| bus_wdata | input | 16 | Host write data |
| bus_raddr | input | 7 | Host read address |
| bus_rdata | output | 16 | Host read data, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |

## Verification
The sequencer can set the finished flag in the same cycle that the host writes 1 to clear it. The bench provokes this by writing the clear on every cycle of a run while it watches the run bit on the separate read address. It stops writing at the first sample where run reads 0, so the completing edge is known to have carried a clear. Reading the status afterwards must show the flag set.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_PRE, S_SHIFT, S_POST} seq_state_t;

  // word length: legal 8..15, anything smaller means a full 16-bit word
  function automatic logic [4:0] eff_bits(input logic [3:0] fld);
    return (fld < 4'd8) ? 5'd16 : {1'b0, fld};
  endfunction

  // system cycles per SCLK phase; zero maps to two
  function automatic logic [7:0] half_cycles(input logic [7:0] baud);
    return (baud == 8'd0) ? 8'd2 : baud;
  endfunction

  // place an n-bit word at the top of the 16-bit shifter
  function automatic logic [15:0] align_left(input logic [15:0] w, input logic [4:0] n);
    return w << (5'd16 - n);
  endfunction
endpackage

// File: rtl/qspi_baud.sv
module qspi_baud #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] half,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assert_phase_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < half));
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift
  import qspi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [15:0] word,
  input  logic [4:0]  nbits,
  input  logic        cpol,
  input  logic        cpha,
  input  logic [7:0]  half,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        done,
  output logic [15:0] rx_word
);
  logic        act_q, sclk_q, done_q;
  logic [15:0] sh_q, rx_q;
  logic [5:0]  edge_q;
  logic        tick;

  qspi_baud #(.W(8)) u_baud (
    .clk(clk), .rst_n(rst_n), .en(act_q), .half(half), .tick(tick)
  );

  // named edge events for the assertions
  wire last_edge = (edge_q == ({nbits, 1'b0} - 6'd1));
  wire leading   = ~edge_q[0];
  wire smp_edge  = cpha ? ~leading : leading;
  wire sft_edge  = cpha ? (leading && (edge_q != 6'd0)) : ~leading;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        act_q  <= 1'b1;
        sh_q   <= align_left(word, nbits);
        rx_q   <= '0;
        edge_q <= '0;
        sclk_q <= cpol;
      end else if (act_q && tick) begin
        sclk_q <= ~sclk_q;
        if (smp_edge) rx_q <= {rx_q[14:0], miso};
        if (sft_edge) sh_q <= {sh_q[14:0], 1'b0};
        if (last_edge) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          edge_q <= edge_q + 6'd1;
        end
      end else if (!act_q) begin
        sclk_q <= cpol;
      end
    end
  end

  assign sclk    = act_q ? sclk_q : cpol;
  assign mosi    = sh_q[15];
  assign done    = done_q;
  assign rx_word = rx_q;

  assert_sclk_home_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (sclk_q == cpol));
  assert_edge_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (edge_q < {nbits, 1'b0}));
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
  import qspi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NCS   = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IW-1:0]  end_ptr,
  input  logic [6:0]     pre_dly,
  input  logic [7:0]     post_dly,
  input  logic [NCS-1:0] cs_idle,
  input  logic [3:0]     bits_fld,
  input  logic           cpol,
  input  logic           cpha,
  input  logic [7:0]     baud,
  input  logic           miso,
  input  logic [15:0]    tx_word,
  input  logic [NCS-1:0] cmd_cs,
  input  logic           cmd_cont,
  output logic [IW-1:0]  idx,
  output logic           rx_we,
  output logic [15:0]    rx_word,
  output logic           entry_end,
  output logic           finish,
  output logic           busy,
  output logic           sclk,
  output logic           mosi,
  output logic [NCS-1:0] cs
);
  seq_state_t     st_q;
  logic [IW-1:0]  idx_q;
  logic [7:0]     dcnt_q;
  logic           hold_q, cont_q;
  logic [NCS-1:0] cs_q;
  logic           sh_done;

  wire go = (st_q == S_PRE) && (dcnt_q == 8'd0);

  qspi_shift u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .word(tx_word),
    .nbits(eff_bits(bits_fld)), .cpol(cpol), .cpha(cpha),
    .half(half_cycles(baud)), .miso(miso), .sclk(sclk), .mosi(mosi),
    .done(sh_done), .rx_word(rx_word)
  );

  assign entry_end = (st_q == S_POST) && (dcnt_q == 8'd0);
  assign finish    = entry_end && (idx_q == end_ptr);
  assign rx_we     = sh_done;
  assign busy      = (st_q != S_IDLE);
  assign idx       = idx_q;
  assign cs        = hold_q ? cs_q : cs_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      dcnt_q <= '0;
      hold_q <= 1'b0;
      cont_q <= 1'b0;
      cs_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          idx_q <= '0;
          st_q  <= S_LOAD;
        end
        S_LOAD: begin
          cs_q   <= cmd_cs;
          cont_q <= cmd_cont;
          hold_q <= 1'b1;
          dcnt_q <= {1'b0, pre_dly};
          st_q   <= S_PRE;
        end
        S_PRE: begin
          if (dcnt_q == 8'd0) st_q <= S_SHIFT;
          else                dcnt_q <= dcnt_q - 8'd1;
        end
        S_SHIFT: if (sh_done) begin
          dcnt_q <= post_dly;
          st_q   <= S_POST;
        end
        S_POST: begin
          if (dcnt_q != 8'd0) begin
            dcnt_q <= dcnt_q - 8'd1;
          end else begin
            if (!cont_q || finish) hold_q <= 1'b0;
            if (finish) st_q <= S_IDLE;
            else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= S_LOAD;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_idle_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> (cs == cs_idle));
  assert_idx_in_queue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= end_ptr));
  assert_rx_in_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (st_q == S_SHIFT));
  assert_next_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_end && !finish) |=> ((st_q == S_LOAD) && (idx_q == $past(idx_q) + 1'b1)));
  assert_cont_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_end && !finish && cont_q) |=> (cs == $past(cs)));
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int NCS   = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int AW   = IW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_waddr,
  input  logic [15:0]    bus_wdata,
  input  logic [AW-1:0]  bus_raddr,
  output logic [15:0]    bus_rdata,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs
);
  // region codes in the top two address bits
  localparam logic [1:0] RG_REG = 2'd0, RG_TX = 2'd1, RG_RX = 2'd2, RG_CMD = 2'd3;

  logic [15:0] txm [DEPTH];
  logic [15:0] rxm [DEPTH];
  logic [7:0]  cmdm [DEPTH];

  logic           master_q, cpol_q, cpha_q, run_q, done_q;
  logic [3:0]     bits_q;
  logic [7:0]     baud_q, post_q;
  logic [6:0]     pre_q;
  logic [IW-1:0]  endp_q, last_q;
  logic [NCS-1:0] idle_q;

  logic [IW-1:0]  seq_idx;
  logic           seq_rx_we, seq_end, seq_finish, seq_busy;
  logic [15:0]    seq_rx_word;

  wire [1:0]    wreg  = bus_waddr[AW-1:AW-2];
  wire [IW-1:0] widx  = bus_waddr[IW-1:0];
  wire [1:0]    rreg  = bus_raddr[AW-1:AW-2];
  wire [IW-1:0] ridx  = bus_raddr[IW-1:0];
  wire          wr_reg = bus_we && (wreg == RG_REG);
  wire          cfg_wr = wr_reg && !seq_busy;
  wire          start  = cfg_wr && (widx[1:0] == 2'd1) && bus_wdata[15];
  wire          clr_done = wr_reg && (widx[1:0] == 2'd3) && bus_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b1;
      bits_q   <= 4'd8;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      baud_q   <= 8'd4;
      run_q    <= 1'b0;
      pre_q    <= '0;
      post_q   <= '0;
      endp_q   <= '0;
      idle_q   <= '1;
      done_q   <= 1'b0;
      last_q   <= '0;
    end else begin
      if (cfg_wr) begin
        case (widx[1:0])
          2'd0: begin
            master_q <= bus_wdata[15];
            bits_q   <= bus_wdata[13:10];
            cpol_q   <= bus_wdata[9];
            cpha_q   <= bus_wdata[8];
            baud_q   <= bus_wdata[7:0];
          end
          2'd1: begin
            run_q  <= bus_wdata[15];
            pre_q  <= bus_wdata[14:8];
            post_q <= bus_wdata[7:0];
          end
          2'd2: begin
            endp_q <= bus_wdata[8 +: IW];
            idle_q <= bus_wdata[NCS-1:0];
          end
          default: ;
        endcase
      end
      if (seq_finish) run_q <= 1'b0;
      if (clr_done)   done_q <= 1'b0;
      if (seq_finish) done_q <= 1'b1;   // set beats a same-cycle clear
      if (seq_end)    last_q <= seq_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        txm[i]  <= '0;
        rxm[i]  <= '0;
        cmdm[i] <= '0;
      end
    end else begin
      if (bus_we && wreg == RG_TX)  txm[widx]  <= bus_wdata;
      if (bus_we && wreg == RG_CMD) cmdm[widx] <= bus_wdata[7:0];
      if (bus_we && wreg == RG_RX)  rxm[widx]  <= bus_wdata;
      if (seq_rx_we)                rxm[seq_idx] <= seq_rx_word;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (rreg)
      RG_REG: case (ridx[1:0])
        2'd0: bus_rdata = {master_q, 1'b0, bits_q, cpol_q, cpha_q, baud_q};
        2'd1: bus_rdata = {run_q, pre_q, post_q};
        2'd2: begin
          bus_rdata[8 +: IW]   = endp_q;
          bus_rdata[NCS-1:0]   = idle_q;
        end
        default: begin
          bus_rdata[7]      = done_q;
          bus_rdata[IW-1:0] = last_q;
        end
      endcase
      RG_TX:   bus_rdata = txm[ridx];
      RG_RX:   bus_rdata = rxm[ridx];
      default: bus_rdata = {8'h00, cmdm[ridx]};
    endcase
  end

  qspi_seq #(.DEPTH(DEPTH), .NCS(NCS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .end_ptr(endp_q),
    .pre_dly(pre_q), .post_dly(post_q), .cs_idle(idle_q),
    .bits_fld(bits_q), .cpol(cpol_q), .cpha(cpha_q), .baud(baud_q),
    .miso(spi_miso), .tx_word(txm[seq_idx]),
    .cmd_cs(cmdm[seq_idx][NCS-1:0]), .cmd_cont(cmdm[seq_idx][7]),
    .idx(seq_idx), .rx_we(seq_rx_we), .rx_word(seq_rx_word),
    .entry_end(seq_end), .finish(seq_finish), .busy(seq_busy),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs(spi_cs)
  );

  assert_run_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q == seq_busy);
  assert_done_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> done_q);
  assert_cfg_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && $past(seq_busy)) |-> ($stable(baud_q) && $stable(endp_q) && $stable(pre_q)));
endmodule

// File: tb/test_qspi_master.sv
`timescale 1ns/1ps
module test_qspi_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_waddr = '0, bus_raddr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs;

  always #2.5 clk = ~clk;   // 200 MHz
  assign spi_miso = ~spi_mosi;  // slave answers the inverted bit

  qspi_master i_qspi_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  localparam logic [6:0] A_SET = 7'h00, A_RUN = 7'h01, A_QUE = 7'h02, A_STA = 7'h03;
  localparam logic [6:0] A_TX = 7'h20, A_RX = 7'h40, A_CMD = 7'h60;

  // {2'b0, lenfield[3:0], cpol, cpha, baud[7:0], txword[15:0]}
  localparam logic [31:0] VEC [8] = '{
    32'h2002_00A5, 32'h2201_003C, 32'h2103_0081, 32'h2300_005A,
    32'h0C02_BEEF, 32'h3105_0ABC, 32'h3F01_7FFE, 32'h0004_1234
  };

  int tests = 0, fails = 0;

  // SPI-side monitor state
  int cyc = 0, nb = 0, nw = 0, nl = 0;
  int last_edge = -1, gmin = 9999, gmax = 0, cs_on = 0, first_gap = 0, rel_gap = 0;
  bit first_pend = 0;
  logic [15:0] acc = '0;
  logic [15:0] words [16];
  logic [3:0]  wcs [16];
  logic [3:0]  cslog [16];
  logic        prev_sclk = 1'b0;
  logic [3:0]  prev_cs = 4'hF;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  int          cfg_n = 8;
  logic [3:0]  cfg_idle = 4'hF;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (spi_cs !== prev_cs) begin
      if (nl < 16) cslog[nl] = spi_cs;
      nl = nl + 1;
      if (prev_cs == cfg_idle) begin cs_on = cyc; first_pend = 1; end
      if (spi_cs == cfg_idle) rel_gap = cyc - last_edge;
    end
    if (spi_cs != cfg_idle && spi_sclk !== prev_sclk) begin
      if (last_edge >= 0) begin
        if (cyc - last_edge < gmin) gmin = cyc - last_edge;
        if (cyc - last_edge > gmax) gmax = cyc - last_edge;
      end
      if (first_pend) begin first_gap = cyc - cs_on; first_pend = 0; end
      if (cfg_cpha ? (prev_sclk != cfg_cpol) : (prev_sclk == cfg_cpol)) begin
        acc = {acc[14:0], spi_mosi};
        nb = nb + 1;
        if (nb == cfg_n) begin
          if (nw < 16) begin words[nw] = acc; wcs[nw] = spi_cs; end
          nw = nw + 1; nb = 0; acc = '0;
        end
      end
      last_edge = cyc;
    end
    prev_sclk = spi_sclk;
    prev_cs   = spi_cs;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); bus_raddr = a; #1; d = bus_rdata;
  endtask

  task automatic arm();
    #1;
    nb = 0; nw = 0; nl = 0; acc = '0; last_edge = -1;
    gmin = 9999; gmax = 0; first_pend = 0;
  endtask

  task automatic wait_done();
    logic [15:0] v;
    for (int k = 0; k < 20000; k++) begin
      rd(A_RUN, v);
      if (!v[15]) return;
    end
    chk("R7 timeout", 32'd1, 32'd0);
  endtask

  function automatic int len_of(input logic [3:0] f);
    return (f >= 4'd8) ? int'(f) : 16;
  endfunction
  function automatic int phase_of(input logic [7:0] b);
    return (b != 8'd0) ? int'(b) : 2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] mask;
    int fa, ra;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_SET, v); chk("R1 setup", v, 16'hA004);
    rd(A_RUN, v); chk("R1 run", v, 16'h0000);
    rd(A_QUE, v); chk("R1 queue", v, 16'h000F);
    rd(A_STA, v); chk("R1 status", v, 16'h0000);
    chk("R1 cs", spi_cs, 4'hF);
    chk("R1 sclk", spi_sclk, 1'b0);

    // R2 slot access
    wr(A_TX | 7'd31, 16'hC0DE); rd(A_TX | 7'd31, v); chk("R2 tx slot", v, 16'hC0DE);
    wr(A_CMD | 7'd5, 16'hFF8A); rd(A_CMD | 7'd5, v); chk("R2 cmd slot", v, 16'h008A);
    wr(A_RX | 7'd7, 16'h5151);  rd(A_RX | 7'd7, v);  chk("R2 rx slot", v, 16'h5151);

    // vector table: single-slot runs over lengths and modes (R3 R4 R9 R10 R11)
    foreach (VEC[i]) begin
      cfg_cpol = VEC[i][25]; cfg_cpha = VEC[i][24]; cfg_n = len_of(VEC[i][29:26]);
      mask = (cfg_n == 16) ? 16'hFFFF : 16'((1 << cfg_n) - 1);
      wr(A_SET, {2'b10, VEC[i][29:26], VEC[i][25], VEC[i][24], VEC[i][23:16]});
      wr(A_QUE, 16'h000F);
      wr(A_TX, VEC[i][15:0]);
      wr(A_CMD, 16'h000E);
      arm();
      wr(A_RUN, 16'h8000);
      wait_done();
      rd(A_RX, v);  chk($sformatf("R4 rx vec%0d", i), v, ~VEC[i][15:0] & mask);
      chk($sformatf("R3 count vec%0d", i), nw, 1);
      chk($sformatf("R3 mosi vec%0d", i), words[0], VEC[i][15:0] & mask);
      chk($sformatf("R9 len vec%0d", i), nb, 0);
      chk($sformatf("R10 min phase vec%0d", i), gmin, phase_of(VEC[i][23:16]));
      chk($sformatf("R10 max phase vec%0d", i), gmax, phase_of(VEC[i][23:16]));
      chk($sformatf("R11 rest vec%0d", i), spi_sclk, VEC[i][25]);
      chk($sformatf("R5 cs vec%0d", i), wcs[0], 4'hE);
    end

    // R3 R5 R7 three slots, continuation after slot 0 only
    cfg_cpol = 0; cfg_cpha = 0; cfg_n = 8;
    wr(A_SET, 16'hA001);
    wr(A_TX | 7'd0, 16'h0011); wr(A_TX | 7'd1, 16'h0022); wr(A_TX | 7'd2, 16'h0033);
    wr(A_CMD | 7'd0, 16'h008E); wr(A_CMD | 7'd1, 16'h000D); wr(A_CMD | 7'd2, 16'h000B);
    wr(A_QUE, 16'h020F);
    arm();
    wr(A_RUN, 16'h8000);
    rd(A_RUN, v); chk("R7 running", v[15], 1'b1);
    wait_done();
    chk("R3 three words", nw, 3);
    chk("R3 order 0", words[0], 16'h0011);
    chk("R3 order 1", words[1], 16'h0022);
    chk("R3 order 2", words[2], 16'h0033);
    chk("R5 cs slot1", wcs[1], 4'hD);
    chk("R5 cs slot2", wcs[2], 4'hB);
    chk("R5 cs changes", nl, 5);
    chk("R5 held E->D", {cslog[0], cslog[1]}, 8'hED);
    chk("R5 release", {cslog[2], cslog[3], cslog[4]}, 12'hFBF);
    rd(A_RX | 7'd1, v); chk("R4 rx slot1", v, 16'h00DD);
    rd(A_RX | 7'd2, v); chk("R4 rx slot2", v, 16'h00CC);
    rd(A_STA, v); chk("R7 status", v, 16'h0082);

    // R8 clear, then set vs clear collision
    wr(A_STA, 16'h0080); rd(A_STA, v); chk("R8 w1c", v[7], 1'b0);
    wr(A_QUE, 16'h000F);
    arm();
    wr(A_RUN, 16'h8000);
    @(negedge clk); bus_we = 1'b1; bus_waddr = A_STA; bus_wdata = 16'h0080; bus_raddr = A_RUN;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk); #0.5;
      if (!bus_rdata[15]) break;
    end
    bus_we = 1'b0;
    rd(A_STA, v); chk("R8 set wins", v[7], 1'b1);

    // R12 delays
    arm(); wr(A_RUN, 16'h8000); wait_done(); fa = first_gap; ra = rel_gap;
    arm(); wr(A_RUN, 16'h940F); wait_done();
    chk("R12 pre delay", first_gap - fa, 20);
    chk("R12 post delay", rel_gap - ra, 15);

    // R13 writes while running are dropped
    arm();
    wr(A_RUN, 16'hE400);
    wr(A_SET, 16'hA0FF); wr(A_QUE, 16'h1F00); wr(A_RUN, 16'h0000);
    rd(A_SET, v); chk("R13 setup kept", v, 16'hA001);
    rd(A_QUE, v); chk("R13 queue kept", v, 16'h000F);
    rd(A_RUN, v); chk("R13 run kept", v, 16'hE400);
    wait_done();
    chk("R13 one word", nw, 1);
    chk("R13 phase kept", gmax, 1);

    // R6 programmable idle level
    cfg_idle = 4'h5;
    wr(A_QUE, 16'h0005);
    chk("R6 idle now", spi_cs, 4'h5);
    wr(A_CMD, 16'h000A);
    arm(); wr(A_RUN, 16'h8000); wait_done();
    chk("R6 active seen", wcs[0], 4'hA);
    chk("R6 idle after", spi_cs, 4'h5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule